// File: doc/BRIEF.md
# BSSID Mask Receive Address Filter

This block decides, for every received frame, whether the frame's 48-bit BSSID belongs to this station, so that the receiver knows whether to acknowledge it. Software programs a 48-bit station MAC address and a 48-bit compare mask through a small word-wide register port. The frame BSSID arrives as a parallel 48-bit value with a one-cycle valid strobe. One clock later the block raises either an accept pulse or a reject pulse.

A mask bit of 1 makes the matching address bit take part in the compare, and a mask bit of 0 drops it. One mask is shared by the station address and every BSSID, so a single compare covers several virtual BSSes at once. The price is that the filter is not exact: a foreign BSSID whose selected bits happen to match is also accepted. Software writes the mask in two parts. The low word is held in a staging register, and the whole 48-bit mask changes in a single step when the upper word is written.

Top module: `bssmask_filter`

## Requirements
- R1: After reset the active mask is all ones, the staged low mask word is all ones, the MAC is zero, and neither pulse is raised.
- R2: A frame is accepted exactly when (bssid AND mask) equals (mac AND mask) over all 48 bits. Otherwise it is rejected.
- R3: Each cycle with bssid_vld high gives exactly one pulse, either acc_pulse or rej_pulse, one clock later and lasting one cycle. No pulse appears in a cycle that does not follow a valid strobe.
- R4: A mask bit of 0 removes that bit from the compare, so frames that differ from the MAC only in such bits are accepted. A mask bit of 1 keeps it, so a difference there causes a reject.
- R5: With an all-ones mask, a frame is accepted only when its BSSID equals the MAC exactly.
- R6: A write to the low mask word (offset 2) changes only the staging register. The active mask stays as it was until the upper word (offset 3) is written. That write then loads all 48 bits in one step.
- R7: The byte order is little-endian. reg_wdata[7:0] written to offset 0 or offset 2 sets bits 7:0 of the MAC or mask. reg_wdata[15:0] written to offset 1 or offset 3 sets bits 47:32.
- R8: reg_rdata combinationally returns the last value written at reg_ofs: offset 0 gives MAC bits 31:0, offset 1 gives MAC bits 47:32, offset 2 gives the staged low mask word, and offset 3 gives the active mask bits 47:32. Bits 31:16 of offsets 1 and 3 read as zero, and writes to those bits are ignored.
- R9: The filter is not exact. With mask 0x2 and MAC 0x1, the frames 0x1, 0x4, 0x9 and 0xD are accepted and 0x6 is rejected.
- R10: A valid strobe on the same clock edge as an upper-mask write is compared against the mask that was active before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write enable |
| reg_ofs | input | 2 | Register offset for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at reg_ofs |
| bssid_vld | input | 1 | Frame BSSID valid strobe |
| bssid | input | 48 | Frame BSSID |
| acc_pulse | output | 1 | Frame accepted, one clock after the strobe |
| rej_pulse | output | 1 | Frame rejected, one clock after the strobe |

## Verification
The bench builds the block with its default parameters: a 48-bit address, a 32-bit register word split into a 32-bit low part and a 16-bit upper part, and 8-bit compare lanes. The address therefore spans six lanes and both register halves. This makes it possible to check that lane reduction is correct across lane boundaries, including differences in bit 0, bit 8 and bit 47. It also makes it possible to check that staging the low word and committing it with the upper word interact correctly with compares issued on the same edge. Unused read-back bits in the upper registers are checked as well.

// File: rtl/bssmask_pkg.sv
package bssmask_pkg;
   localparam int REG_AW = 2;
   typedef enum logic [REG_AW-1:0] {
      OFS_MAC_LO = 2'd0,
      OFS_MAC_HI = 2'd1,
      OFS_MSK_LO = 2'd2,
      OFS_MSK_HI = 2'd3
   } reg_ofs_e;
endpackage

// File: rtl/bssmask_regs.sv
module bssmask_regs
   import bssmask_pkg::*;
#(
   parameter int ADDR_W = 48,
   parameter int DATA_W = 32,
   parameter int LO_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] ofs,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mac,
   output logic [ADDR_W-1:0] mask
);
   localparam int HI_W = ADDR_W - LO_W;

   generate
      if (HI_W < 1 || HI_W > DATA_W || LO_W > DATA_W || LO_W < 1) begin : g_bad_split
         $error("bssmask_regs: address split does not fit the register word");
      end
   endgenerate

   logic [LO_W-1:0] stage_lo;
   logic            wr_mac_lo, wr_mac_hi, wr_msk_lo, wr_msk_hi;

   always_comb begin
      wr_mac_lo = wr_en && (ofs == OFS_MAC_LO);
      wr_mac_hi = wr_en && (ofs == OFS_MAC_HI);
      wr_msk_lo = wr_en && (ofs == OFS_MSK_LO);
      wr_msk_hi = wr_en && (ofs == OFS_MSK_HI);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mac      <= '0;
         mask     <= '1;
         stage_lo <= '1;
      end else begin
         if (wr_mac_lo) mac[LO_W-1:0]      <= wr_data[LO_W-1:0];
         if (wr_mac_hi) mac[ADDR_W-1:LO_W] <= wr_data[HI_W-1:0];
         if (wr_msk_lo) stage_lo           <= wr_data[LO_W-1:0];
         if (wr_msk_hi) mask               <= {wr_data[HI_W-1:0], stage_lo};
      end
   end

   always_comb begin
      rd_data = '0;
      case (ofs)
         OFS_MAC_LO: rd_data[LO_W-1:0] = mac[LO_W-1:0];
         OFS_MAC_HI: rd_data[HI_W-1:0] = mac[ADDR_W-1:LO_W];
         OFS_MSK_LO: rd_data[LO_W-1:0] = stage_lo;
         default:    rd_data[HI_W-1:0] = mask[ADDR_W-1:LO_W];
      endcase
   end

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && ofs == OFS_MSK_HI) |=> $stable(mask)); // R6
   AST_MAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (ofs == OFS_MAC_LO || ofs == OFS_MAC_HI)) |=> $stable(mac)); // R8
endmodule

// File: rtl/bssmask_cmp.sv
module bssmask_cmp #(
   parameter int ADDR_W = 48,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld,
   input  logic [ADDR_W-1:0] bssid,
   input  logic [ADDR_W-1:0] mac,
   input  logic [ADDR_W-1:0] mask,
   output logic              acc,
   output logic              rej
);
   localparam int NLANE = (ADDR_W + LANE_W - 1) / LANE_W;
   localparam int PAD_W = NLANE * LANE_W;

   generate
      if (LANE_W < 1 || LANE_W > ADDR_W) begin : g_bad_lane
         $error("bssmask_cmp: lane width out of range");
      end
   endgenerate

   logic [PAD_W-1:0] diff_pad;
   logic [NLANE-1:0] lane_miss;
   logic             any_miss;

   always_comb begin
      diff_pad = '0;
      diff_pad[ADDR_W-1:0] = (bssid ^ mac) & mask;
   end

   genvar li;
   generate
      for (li = 0; li < NLANE; li++) begin : g_lane
         assign lane_miss[li] = |diff_pad[li*LANE_W +: LANE_W];
      end
   endgenerate

   assign any_miss = |lane_miss;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= 1'b0;
         rej <= 1'b0;
      end else begin
         acc <= vld && !any_miss;
         rej <= vld && any_miss;
      end
   end

   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && rej)); // R3
   AST_VLD_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      vld |=> (acc || rej)); // R3
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc || rej) |-> $past(vld)); // R3
   AST_EXACT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && (&mask)) |=> (acc == ($past(bssid) == $past(mac)))); // R5
   AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && mask == '0) |=> acc); // R4
endmodule

// File: rtl/bssmask_filter.sv
module bssmask_filter
   import bssmask_pkg::*;
#(
   parameter int ADDR_W = 48,
   parameter int DATA_W = 32,
   parameter int LO_W   = 32,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_ofs,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              bssid_vld,
   input  logic [ADDR_W-1:0] bssid,
   output logic              acc_pulse,
   output logic              rej_pulse
);
   logic [ADDR_W-1:0] mac_q;
   logic [ADDR_W-1:0] mask_q;

   bssmask_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO_W(LO_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .ofs     (reg_ofs),
      .wr_data (reg_wdata),
      .rd_data (reg_rdata),
      .mac     (mac_q),
      .mask    (mask_q)
   );

   bssmask_cmp #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (bssid_vld),
      .bssid (bssid),
      .mac   (mac_q),
      .mask  (mask_q),
      .acc   (acc_pulse),
      .rej   (rej_pulse)
   );
endmodule

// File: tb/sim_bssmask_filter.sv
`timescale 1ns/1ps
module sim_bssmask_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_ofs = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        bssid_vld = 1'b0;
   logic [47:0] bssid = '0;
   logic        acc_pulse, rej_pulse;

   always #2 clk = ~clk;

   bssmask_filter u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ofs(reg_ofs),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bssid_vld(bssid_vld),
      .bssid(bssid), .acc_pulse(acc_pulse), .rej_pulse(rej_pulse)
   );

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   logic [47:0] m_mac, m_mask;
   logic [31:0] m_stage;
   logic        e_acc, e_rej;
   logic [31:0] e_rd;

   task automatic check(input string req, input string what,
                        input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // reference model and per-clock comparison
   always @(posedge clk) begin
      if (!rst_n) begin
         m_mac = '0; m_mask = '1; m_stage = '1; e_acc = 0; e_rej = 0;
      end else begin
         if (bssid_vld) begin
            e_acc = ((bssid & m_mask) == (m_mac & m_mask));
            e_rej = !e_acc;
         end else begin
            e_acc = 0; e_rej = 0;
         end
         if (reg_wr) begin
            case (reg_ofs)
               2'd0: m_mac[31:0]  = reg_wdata;
               2'd1: m_mac[47:32] = reg_wdata[15:0];
               2'd2: m_stage      = reg_wdata;
               default: m_mask    = {reg_wdata[15:0], m_stage};
            endcase
         end
      end
      #1;
      case (reg_ofs)
         2'd0: e_rd = m_mac[31:0];
         2'd1: e_rd = {16'h0, m_mac[47:32]};
         2'd2: e_rd = m_stage;
         default: e_rd = {16'h0, m_mask[47:32]};
      endcase
      if (rst_n && !done) begin
         check(cur_req, "acc_pulse", {47'h0, acc_pulse}, {47'h0, e_acc});
         check(cur_req, "rej_pulse", {47'h0, rej_pulse}, {47'h0, e_rej});
         check(cur_req, "reg_rdata", {16'h0, reg_rdata}, {16'h0, e_rd});
      end
   end

   task automatic step(input logic wr, input logic [1:0] ofs, input logic [31:0] wd,
                       input logic v, input logic [47:0] b);
      @(negedge clk);
      reg_wr = wr; reg_ofs = ofs; reg_wdata = wd; bssid_vld = v; bssid = b;
   endtask

   task automatic wreg(input logic [1:0] ofs, input logic [31:0] wd);
      step(1'b1, ofs, wd, 1'b0, '0);
   endtask

   task automatic frame(input logic [47:0] b);
      step(1'b0, 2'd0, '0, 1'b1, b);
   endtask

   task automatic idle(input logic [1:0] ofs);
      step(1'b0, ofs, '0, 1'b0, '0);
   endtask

   task automatic set_mask(input logic [47:0] m);
      wreg(2'd2, m[31:0]);
      wreg(2'd3, {16'h0, m[47:32]});
   endtask

   task automatic set_mac(input logic [47:0] m);
      wreg(2'd0, m[31:0]);
      wreg(2'd1, {16'h0, m[47:32]});
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values readable, no pulses
      cur_req = "R1";
      for (int i = 0; i < 4; i++) idle(i[1:0]);

      // R7: MAC byte order and placement
      cur_req = "R7";
      set_mac(48'h0123_4567_89AB);
      idle(2'd0); idle(2'd1);

      // R5: exact match with all-ones mask
      cur_req = "R5";
      frame(48'h0123_4567_89AB);
      frame(48'h0123_4567_89AA);
      frame(48'h8123_4567_89AB);
      frame(48'h0123_4567_88AB);
      idle(2'd0);

      // R6: staged low word has no effect until upper write
      cur_req = "R6";
      wreg(2'd2, 32'hFFFF_FF00);
      idle(2'd2);
      frame(48'h0123_4567_89AC);   // differs in bits 7:0, still compared
      wreg(2'd3, 32'h0000_FFFF);
      frame(48'h0123_4567_89AC);   // now ignored
      idle(2'd3);

      // R10: frame on same edge as upper commit uses old mask
      cur_req = "R10";
      wreg(2'd2, 32'hFFFF_FFFF);
      step(1'b1, 2'd3, 32'h0000_FFFF, 1'b1, 48'h0123_4567_8900);
      frame(48'h0123_4567_8900);
      idle(2'd3);

      // R4: ignored bits vs compared bits, across lane edges
      cur_req = "R4";
      set_mask(48'h7FFF_FFFF_FEFE);
      frame(48'h8123_4567_88AA);
      frame(48'h0123_4567_88AB);
      frame(48'h0123_4567_89AF);
      set_mask(48'h0);
      frame(48'hFFFF_FFFF_FFFF);

      // R2: back-to-back frames, mixed results
      cur_req = "R2";
      set_mask(48'hF0F0_0F0F_00FF);
      for (int i = 0; i < 8; i++)
         frame(48'h0123_4567_89AB ^ (48'h1 << (i * 6)));
      idle(2'd0);

      // R9: inexact filtering
      cur_req = "R9";
      set_mac(48'h1);
      set_mask(48'h2);
      frame(48'h1); frame(48'h4); frame(48'h9); frame(48'hD); frame(48'h6);
      idle(2'd0);

      // R8: unused upper bits read zero
      cur_req = "R8";
      wreg(2'd1, 32'hABCD_1234);
      idle(2'd1);
      wreg(2'd3, 32'h5A5A_FFFF);
      idle(2'd3);
      wreg(2'd2, 32'hDEAD_BEEF);
      idle(2'd2);

      // R3: mixed random traffic
      cur_req = "R3";
      for (int i = 0; i < 400; i++) begin
         logic [47:0] r;
         r = {$urandom, $urandom};
         if ($urandom_range(0, 5) == 0)
            step(1'b1, 2'($urandom_range(0, 3)), $urandom, $urandom_range(0, 1) == 1,
                 m_mac ^ (r & {$urandom, $urandom} & {$urandom, $urandom}));
         else
            step(1'b0, 2'($urandom_range(0, 3)), '0, $urandom_range(0, 2) != 0,
                 m_mac ^ (r & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}));
      end
      idle(2'd0); idle(2'd0);
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule